// File: doc/BRIEF.md
# Latch-Paced Serial Byte Pusher

This block takes bytes out of a 256-entry circular receive buffer and moves each one bit by bit into an external serial-in, parallel-out shift register. It drives a data line and a shift clock line. The block owns the buffer's read pointer. It compares that pointer with the writer's pointer to learn whether a byte is waiting, and it reads the entry at its pointer through a combinational read port.

An external set/reset latch paces the transfer. The consumer sets the latch when it has read the parallel register. The block starts a byte only when a byte is waiting and the latch reports that the previous byte has been collected. When the eighth bit is in place, the block releases the data line and pulses the latch reset once. This clears the latch and tells the consumer that fresh data is ready.

During shifting, each shift clock period has a low phase and a high phase. Their lengths are set by parameters and counted in system clock cycles.

Top module: `serial_byte_pusher`

## Requirements
- R1: After reset the shift clock is high, the latch reset output is low, the data line is not driven (enable low, data low), busy is low and the read pointer is 0.
- R2: While the read pointer equals the write pointer, no byte starts and no clock pulse is issued, even with the latch status high.
- R3: While the latch status is low, a waiting byte is held back. It starts once the status goes high.
- R4: Bits leave most significant first. Each bit is placed on the data line before the shift clock falls, and it stays unchanged until the clock rises again, which is where the external register captures it.
- R5: Each byte produces exactly eight shift clock pulses, and each low phase lasts LOW_CYC system cycles.
- R6: After the eighth rising edge, the latch reset output goes high for exactly one system cycle and then returns low. The next byte can begin only after that.
- R7: The read pointer advances by one for each byte taken, and it wraps from 255 to 0.
- R8: The data line enable is high only while bits are being shifted. It is low during the latch reset pulse and while idle, and busy is high whenever the enable is.
- R9: The latch status is examined again before every byte. A byte taken with the status high lets no further byte through until the consumer sets the latch again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_ptr | input | AW | Write pointer of the receive buffer |
| rd_data | input | 8 | Buffer entry at rd_ptr (combinational read) |
| ready_in | input | 1 | Latch status: high when the consumer has taken the last byte |
| rd_ptr | output | AW | Read pointer of the receive buffer |
| sdata_out | output | 1 | Serial data to the shift register |
| sdata_oe | output | 1 | Drive enable for the shared data line |
| sclk | output | 1 | Shift clock, idles high, register captures on rising edge |
| latch_rst | output | 1 | One-cycle pulse that clears the external latch |
| busy | output | 1 | High from byte start through the latch reset pulse |

## Verification
Two functions can meet in the same cycle. One is the read pointer wrapping from 255 to 0 as the last buffer entry is taken. The other is the writer's pointer moving off 0 as a new entry 0 arrives. The bench streams the buffer until the read pointer wraps, and in the very cycle the wrap shows at the port it advances the write pointer to 1. It then expects exactly one extra byte, carrying entry 0, with the read pointer ending at 1 and every earlier byte received in order with the right value.

// File: rtl/serial_byte_pusher.sv
module serial_byte_pusher #(
  parameter int AW       = 8,
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] wr_ptr,
  input  logic [7:0]    rd_data,
  input  logic          ready_in,
  output logic [AW-1:0] rd_ptr,
  output logic          sdata_out,
  output logic          sdata_oe,
  output logic          sclk,
  output logic          latch_rst,
  output logic          busy
);

  localparam int MAXPH = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW    = (MAXPH < 2) ? 1 : $clog2(MAXPH);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_LATCH} st_t;

  st_t           state;
  logic [7:0]    shreg;
  logic [2:0]    bitn;
  logic [CW-1:0] tmr;
  logic [AW-1:0] rp;

  wire empty = (rp == wr_ptr);
  wire start = (state == S_IDLE) && !empty && ready_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      shreg <= '0;
      bitn  <= '0;
      tmr   <= '0;
      rp    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          shreg <= rd_data;
          rp    <= rp + 1'b1;
          bitn  <= '0;
          state <= S_SETUP;
        end
        S_SETUP: begin
          tmr   <= '0;
          state <= S_LOW;
        end
        S_LOW: if (tmr == CW'(LOW_CYC - 1)) begin
          tmr   <= '0;
          state <= S_HIGH;
        end else tmr <= tmr + 1'b1;
        S_HIGH: if (tmr == CW'(HIGH_CYC - 1)) begin
          tmr <= '0;
          if (bitn == 3'd7) state <= S_LATCH;
          else begin
            bitn  <= bitn + 1'b1;
            shreg <= {shreg[6:0], 1'b0};
            state <= S_SETUP;
          end
        end else tmr <= tmr + 1'b1;
        S_LATCH: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rd_ptr    = rp;
  assign sdata_oe  = (state == S_SETUP) || (state == S_LOW) || (state == S_HIGH);
  assign sdata_out = sdata_oe & shreg[7];
  assign sclk      = (state != S_LOW);
  assign latch_rst = (state == S_LATCH);
  assign busy      = (state != S_IDLE);

  p_no_start_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rd_ptr == wr_ptr) |=> !busy);

  p_gate_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ready_in) && $past(rd_ptr != wr_ptr)));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && $past(!sclk)) |-> $stable(sdata_out));

  p_clk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> sclk);

  p_lrst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_rst |=> (!latch_rst && !busy));

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr != $past(rd_ptr)) |-> (rd_ptr == AW'($past(rd_ptr) + 1'b1)));

  p_oe_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> (busy && !latch_rst));

endmodule

// File: tb/sim_serial_byte_pusher.sv
`timescale 1ns/1ps
module sim_serial_byte_pusher;
  localparam int LOWC = 3;
  localparam int HIGHC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] wr_ptr = '0;
  logic [7:0] rd_data;
  logic ready_in;
  logic [7:0] rd_ptr;
  logic sdata_out, sdata_oe, sclk, latch_rst, busy;

  logic [7:0] mem [256];
  logic set_req = 1'b0;
  logic auto_ack = 1'b0;
  logic latch_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] rx [512];
  int nrx = 0;

  always #4 clk = ~clk;

  assign rd_data  = mem[rd_ptr];
  assign ready_in = latch_q;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) latch_q <= 1'b0;
    else if (latch_rst) latch_q <= 1'b0;
    else if (set_req || auto_ack) latch_q <= 1'b1;

  serial_byte_pusher #(.AW(8), .LOW_CYC(LOWC), .HIGH_CYC(HIGHC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_data(rd_data),
    .ready_in(ready_in), .rd_ptr(rd_ptr), .sdata_out(sdata_out),
    .sdata_oe(sdata_oe), .sclk(sclk), .latch_rst(latch_rst), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // port monitor: samples at the falling edge of clk
  logic prev_sclk = 1'b1, prev_lr = 1'b0;
  logic [7:0] sh = '0;
  logic fall_d = 1'b0;
  int lowcnt = 0, npulse = 0, bad_low = 0, bad_stab = 0, bad_oe = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!sclk) begin
        if (prev_sclk) begin fall_d = sdata_out; lowcnt = 1; end
        else lowcnt++;
      end else if (!prev_sclk) begin
        npulse++;
        if (lowcnt != LOWC) bad_low++;
        if (sdata_out != fall_d) bad_stab++;
        if (!sdata_oe) bad_oe++;
        sh = {sh[6:0], sdata_out};
      end
      if (latch_rst && prev_lr)
        chk(1'b0, "R6 latch reset wider than one cycle", 2, 1);
      if (latch_rst && !prev_lr) begin
        chk(npulse == 8, "R5 pulses per byte", npulse, 8);
        chk(bad_low == 0 && bad_stab == 0, "R4/R5 low phase length and data hold", bad_low + bad_stab, 0);
        chk(!sdata_oe && bad_oe == 0, "R8 data driven at capture, released at latch pulse", bad_oe + sdata_oe, 0);
        rx[nrx] = sh;
        nrx++;
        npulse = 0; bad_low = 0; bad_stab = 0; bad_oe = 0;
      end
      if (!busy) chk(!sdata_oe && sclk, "R8 idle line released, clock high", {sdata_oe, sclk}, 1);
      prev_sclk = sclk;
      prev_lr = latch_rst;
    end
  end

  task automatic wait_idle(input int n);
    repeat (n) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(sclk == 1'b1 && latch_rst == 1'b0, "R1 clock high, latch reset low", {sclk, latch_rst}, 2);
    chk(sdata_oe == 1'b0 && sdata_out == 1'b0 && busy == 1'b0, "R1 line released, not busy", {sdata_oe, sdata_out, busy}, 0);
    chk(rd_ptr == 8'd0, "R1 read pointer", rd_ptr, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_empty;
    set_req = 1'b1;
    @(negedge clk);
    set_req = 1'b0;
    repeat (60) @(negedge clk);
    chk(nrx == 0, "R2 no byte while empty", nrx, 0);
    chk(rd_ptr == 8'd0 && sclk && !busy, "R2 pointer and clock unchanged", rd_ptr, 0);
  endtask

  task automatic t_gated;
    mem[0] = 8'hA5; mem[1] = 8'h3C;
    wr_ptr = 8'd2;
    wait_idle(5);
    chk(nrx == 1, "R9 one byte per latch set", nrx, 1);
    chk(rx[0] == 8'hA5, "R4 msb-first byte A5", rx[0], 8'hA5);
    chk(rd_ptr == 8'd1, "R7 pointer after one byte", rd_ptr, 1);
    chk(ready_in == 1'b0, "R6 latch cleared by pulse", ready_in, 0);
    repeat (80) @(negedge clk);
    chk(nrx == 1 && !busy, "R3 held while latch low", nrx, 1);
    set_req = 1'b1;
    @(negedge clk);
    set_req = 1'b0;
    wait_idle(5);
    chk(nrx == 2 && rx[1] == 8'h3C, "R3 starts after latch set, byte 3C", rx[1], 8'h3C);
    chk(rd_ptr == 8'd2, "R7 pointer after two bytes", rd_ptr, 2);
  endtask

  task automatic t_patterns;
    logic [7:0] pat [5];
    int base;
    pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'h80; pat[3] = 8'h01; pat[4] = 8'h55;
    base = nrx;
    for (int i = 0; i < 5; i++) mem[2 + i] = pat[i];
    wr_ptr = 8'd7;
    auto_ack = 1'b1;
    wait_idle(5);
    while (rd_ptr != 8'd7 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
    auto_ack = 1'b0;
    chk(nrx == base + 5, "R9 streamed byte count", nrx - base, 5);
    for (int i = 0; i < 5; i++)
      chk(rx[base + i] == pat[i], "R4 pattern byte", rx[base + i], pat[i]);
  endtask

  task automatic t_wrap;
    int base, start;
    start = rd_ptr;
    base = nrx;
    for (int k = 0; k < 256; k++) mem[k] = 8'(k * 7 + 3);
    mem[0] = 8'hC3;
    wr_ptr = 8'd0;
    auto_ack = 1'b1;
    @(negedge clk);
    while (rd_ptr != 8'd0) @(negedge clk);
    wr_ptr = 8'd1;
    wait_idle(5);
    repeat (80) @(negedge clk);
    auto_ack = 1'b0;
    chk(nrx - base == 256 - start + 1, "R7 bytes across wrap", nrx - base, 256 - start + 1);
    chk(rd_ptr == 8'd1, "R7 pointer wrapped to 1", rd_ptr, 1);
    for (int k = start; k < 256; k++)
      if (rx[base + k - start] != 8'(k * 7 + 3))
        chk(1'b0, "R7 stream order", rx[base + k - start], 8'(k * 7 + 3));
    chk(rx[nrx - 1] == 8'hC3, "R7 entry 0 sent after wrap", rx[nrx - 1], 8'hC3);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    t_empty();
    t_gated();
    t_patterns();
    t_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule